// File: doc/BRIEF.md
# GPIO Port with Pin Interrupt Detection

The block is a 32-pin general-purpose I/O port on a plain memory-mapped register bus with an address, a write strobe, write data and combinational read data. Each pin has a data bit that drives its output value and a direction bit that drives its output enable. The pad inputs can be read back after synchronization. The tristate buffers themselves sit outside the block.

Every pin can raise an interrupt. Its synchronized input is compared against a 2-bit sense code, which selects low level, high level, rising edge or falling edge. A match sets the pin's bit in a sticky status register, and software clears that bit by writing a one to it. A mask register decides which status bits may drive the single interrupt line. Edge modes compare the current synchronized sample with the one taken a cycle earlier. Level modes set status again on every cycle that the level is present.

Top module: `gpio_port`

## Requirements
- R1: While reset is held, every register reads 0, pin_o and pin_oe_o are 0 and irq_o is 0.
- R2: A write to word 0x00 loads the data register. The write shows on pin_o after the clock edge, and the register reads back unchanged from 0x00.
- R3: A write to word 0x04 loads the direction register, and pin_oe_o equals it after the edge. Bit value 1 makes the pin an output and 0 makes it an input. The register reads back from 0x04.
- R4: Reading 0x08 returns pin_i after two flip-flop stages, so a pin change shows on the second rising edge. Writes to 0x08 are ignored.
- R5: Sense codes for pins 0..15 sit in the register at 0x0C and those for pins 16..31 in the register at 0x10. Pin p uses bits [2*(p%16)+1 : 2*(p%16)]. The codes are 0 = low level, 1 = high level, 2 = rising edge and 3 = falling edge. Both registers read back what was written.
- R6: In a level mode, the status bit is set on every cycle that the synchronized pin holds that level. A clear therefore only sticks once the level has gone.
- R7: In an edge mode, the status bit is set once when the synchronized input changes in the chosen direction. It stays set until cleared, and it is set in no other way.
- R8: Writing 0x18 clears each status bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged. The status register reads back from 0x18.
- R9: When a detection and a clear hit the same status bit in the same cycle, the bit ends up set.
- R10: The mask register at 0x14 reads back as written, and its reset value is 0. irq_o is 1 exactly when some status bit and its mask bit are both 1. The mask has no effect on how status bits are set.
- R11: Word 0x1C, and any address with nonzero bits [1:0], reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| pin_i | input | 32 | Pad inputs, asynchronous |
| pin_o | output | 32 | Pad output values |
| pin_oe_o | output | 32 | Pad output enables |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a clear that lands in the same cycle as a detection. Level modes reach it on their own: a pin held at its active level while status is cleared retriggers in the clear cycle. The stimulus sets this up directly for a high-level pin, and it arises again during random runs of configuration writes and pin toggles. A second hard case is an edge that arrives during the two synchronizer cycles, so the bench keeps a cycle-exact model of the two stages and the previous-sample flop and compares every register on every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_HIGH = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_FALL = 2'd3
  } sense_e;

  localparam logic [2:0] IDX_DATA   = 3'd0;
  localparam logic [2:0] IDX_DIR    = 3'd1;
  localparam logic [2:0] IDX_PAD    = 3'd2;
  localparam logic [2:0] IDX_CFG_LO = 3'd3;
  localparam logic [2:0] IDX_CFG_HI = 3'd4;
  localparam logic [2:0] IDX_MASK   = 3'd5;
  localparam logic [2:0] IDX_STAT   = 3'd6;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0]   cur_i,
  input  logic [N-1:0]   prev_i,
  input  logic [2*N-1:0] sense_i,
  output logic [N-1:0]   set_o
);
  for (genvar p = 0; p < N; p++) begin : g_pin
    sense_e mode;
    assign mode = sense_e'(sense_i[2*p +: 2]);
    always_comb begin
      unique case (mode)
        SENSE_LOW:  set_o[p] = ~cur_i[p];
        SENSE_HIGH: set_o[p] = cur_i[p];
        SENSE_RISE: set_o[p] = cur_i[p] & ~prev_i[p];
        SENSE_FALL: set_o[p] = ~cur_i[p] & prev_i[p];
        default:    set_o[p] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pin_i,
  output logic [DW-1:0] pin_o,
  output logic [DW-1:0] pin_oe_o,
  output logic          irq_o
);
  localparam int unsigned HALF = DW / 2;

  logic [DW-1:0] data_q, dir_q, mask_q, status_q;
  logic [DW-1:0] cfg_lo_q, cfg_hi_q;
  logic [DW-1:0] sync_w, prev_w, set_vec;
  logic [2:0]    idx;
  logic          aligned;
  logic [DW-1:0] clr_vec;

  assign idx     = addr_i[AW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  gpio_sync #(.N(DW)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pin_i),
    .sync_o (sync_w),
    .prev_o (prev_w)
  );

  // Pin p field lands at bit 2p of the concatenation for both halves.
  gpio_detect #(.N(DW)) u_detect (
    .cur_i  (sync_w),
    .prev_i (prev_w),
    .sense_i({cfg_hi_q[2*HALF-1:0], cfg_lo_q[2*HALF-1:0]}),
    .set_o  (set_vec)
  );

  assign clr_vec = (we_i && aligned && idx == IDX_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
    end else if (we_i && aligned) begin
      unique case (idx)
        IDX_DATA:   data_q   <= wdata_i;
        IDX_DIR:    dir_q    <= wdata_i;
        IDX_CFG_LO: cfg_lo_q <= wdata_i;
        IDX_CFG_HI: cfg_hi_q <= wdata_i;
        IDX_MASK:   mask_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  // Set has priority over write-one-to-clear.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_vec) | set_vec;
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      unique case (idx)
        IDX_DATA:   rdata_o = data_q;
        IDX_DIR:    rdata_o = dir_q;
        IDX_PAD:    rdata_o = sync_w;
        IDX_CFG_LO: rdata_o = cfg_lo_q;
        IDX_CFG_HI: rdata_o = cfg_hi_q;
        IDX_MASK:   rdata_o = mask_q;
        IDX_STAT:   rdata_o = status_q;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign pin_o    = data_q;
  assign pin_oe_o = dir_q;
  assign irq_o    = |(status_q & mask_q);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] pin_o,
  input logic [DW-1:0] pin_oe_o,
  input logic          irq_o,
  input logic [DW-1:0] status_i,
  input logic [DW-1:0] mask_i,
  input logic [DW-1:0] set_i
);
  logic wr_data, wr_dir, wr_stat;
  assign wr_data = we_i && addr_i == {IDX_DATA, 2'b00};
  assign wr_dir  = we_i && addr_i == {IDX_DIR, 2'b00};
  assign wr_stat = we_i && addr_i == {IDX_STAT, 2'b00};

  assert_data_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> pin_o == $past(wdata_i));

  assert_dir_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir |=> pin_oe_o == $past(wdata_i));

  assert_status_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_i & ~$past(status_i) & ~$past(set_i)) == '0));

  assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat |=> ((status_i & $past(wdata_i & ~set_i)) == '0));

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_i & $past(set_i)) == $past(set_i)));

  assert_irq_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o);

  assert_irq_stat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == '0) |-> !irq_o);
endmodule

bind gpio_port gpio_port_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o),
  .irq_o   (irq_o),
  .status_i(status_q),
  .mask_i  (mask_q),
  .set_i   (set_vec)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam time TCK = 20ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] pin_i = '0;
  logic [31:0] rdata_o, pin_o, pin_oe_o;
  logic        irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_data, m_dir, m_lo, m_hi, m_mask, m_st, m_s1, m_s2, m_prev;

  always #(TCK/2) clk_i = ~clk_i;

  gpio_port u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] f_detect(logic [31:0] cur, logic [31:0] prv,
                                           logic [31:0] lo, logic [31:0] hi);
    logic [31:0] r = '0;
    for (int p = 0; p < 32; p++) begin
      logic [1:0] code = (p < 16) ? lo[2*p +: 2] : hi[2*(p-16) +: 2];
      case (code)
        2'd0: r[p] = !cur[p];
        2'd1: r[p] = cur[p];
        2'd2: r[p] = cur[p] && !prv[p];
        default: r[p] = !cur[p] && prv[p];
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] f_read(logic [4:0] a);
    if (a[1:0] != 2'b00) return '0;
    case (a[4:2])
      3'd0: return m_data;
      3'd1: return m_dir;
      3'd2: return m_s2;
      3'd3: return m_lo;
      3'd4: return m_hi;
      3'd5: return m_mask;
      3'd6: return m_st;
      default: return '0;
    endcase
  endfunction

  function automatic string f_req(logic [4:0] a);
    if (a[1:0] != 2'b00) return "R11";
    case (a[4:2])
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      3'd5: return "R10";
      3'd6: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge: drive, compare against model, advance one clock.
  task automatic tick(logic we, logic [4:0] a, logic [31:0] wd, logic [31:0] pins);
    logic [31:0] set, clr;
    we_i = we; addr_i = a; wdata_i = wd; pin_i = pins;
    #1;
    chk(f_req(a), rdata_o, f_read(a));
    chk("R2", pin_o, m_data);
    chk("R3", pin_oe_o, m_dir);
    chk("R10", {31'd0, irq_o}, {31'd0, |(m_st & m_mask)});
    set = f_detect(m_s2, m_prev, m_lo, m_hi);
    clr = (we && a == 5'h18) ? wd : '0;
    @(posedge clk_i);
    m_st = (m_st & ~clr) | set;
    if (we && a[1:0] == 2'b00) begin
      case (a[4:2])
        3'd0: m_data = wd;
        3'd1: m_dir = wd;
        3'd3: m_lo = wd;
        3'd4: m_hi = wd;
        3'd5: m_mask = wd;
        default: ;
      endcase
    end
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic probe(string req, logic [4:0] a, logic [31:0] exp);
    we_i = 1'b0; addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] pins;
    logic [4:0]  a;
    void'($urandom(32'h5eed_0042));
    {m_data, m_dir, m_lo, m_hi, m_mask, m_st, m_s1, m_s2, m_prev} = '0;

    // R1: reset state
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < 8; i++) probe("R1", 5'(i * 4), 32'h0);
    chk("R1", pin_o | pin_oe_o, 32'h0);
    chk("R1", {31'd0, irq_o}, 32'h0);
    rst_ni = 1'b1;

    // R7/R5: pin 20 rising edge (high config bits 9:8 = 2), all pins high
    pins = 32'hFFFF_FFFF;
    tick(1, 5'h10, 32'h0000_0200, pins);
    tick(1, 5'h14, 32'h0010_0000, pins);
    repeat (4) tick(0, 5'h00, 0, pins);
    tick(1, 5'h18, 32'hFFFF_FFFF, pins);
    pins[20] = 1'b0;
    repeat (4) tick(0, 5'h00, 0, pins);
    probe("R7", 5'h18, 32'h0);
    chk("R7", {31'd0, irq_o}, 32'h0);
    pins[20] = 1'b1;
    repeat (4) tick(0, 5'h00, 0, pins);
    probe("R7", 5'h18, 32'h0010_0000);
    chk("R10", {31'd0, irq_o}, 32'h1);
    tick(1, 5'h18, 32'h0, pins);
    probe("R8", 5'h18, 32'h0010_0000);
    tick(1, 5'h18, 32'h0010_0000, pins);
    probe("R8", 5'h18, 32'h0);
    chk("R10", {31'd0, irq_o}, 32'h0);

    // R6/R9: pin 3 high level (low config bits 7:6 = 1), held high
    tick(1, 5'h0C, 32'h0000_0040, pins);
    repeat (4) tick(0, 5'h00, 0, pins);
    tick(1, 5'h18, 32'h0000_0008, pins);
    probe("R9", 5'h18, 32'h0000_0008);
    pins[3] = 1'b0;
    repeat (4) tick(0, 5'h00, 0, pins);
    tick(1, 5'h18, 32'h0000_0008, pins);
    probe("R6", 5'h18, 32'h0);

    // R4: pad readback latency, write ignored
    tick(1, 5'h08, 32'h1234_5678, 32'hA5A5_0F0F);
    probe("R4", 5'h08, 32'h0000_0000 | (pins & 32'hFFFF_FFFF));
    tick(0, 5'h00, 0, 32'hA5A5_0F0F);
    probe("R4", 5'h08, 32'hA5A5_0F0F);

    // R11: unmapped and misaligned
    tick(1, 5'h1C, 32'hDEAD_BEEF, 32'hA5A5_0F0F);
    probe("R11", 5'h1C, 32'h0);
    tick(1, 5'h01, 32'hDEAD_BEEF, 32'hA5A5_0F0F);
    probe("R11", 5'h00, m_data);
    probe("R11", 5'h01, 32'h0);

    // Random phase
    pins = 32'hA5A5_0F0F;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] wd;
      if ($urandom_range(0, 3) == 0) pins ^= (32'h1 << $urandom_range(0, 31));
      a = ($urandom_range(0, 15) == 0) ? 5'($urandom) : 5'($urandom_range(0, 7) * 4);
      wd = $urandom;
      if (a == 5'h18 && $urandom_range(0, 1) == 0) wd = 32'hFFFF_FFFF;
      tick($urandom_range(0, 2) == 0, a, wd, pins);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule